// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block produces the six arithmetic condition bits for an integer datapath of configurable width (32 bits by default). The datapath gives it both operands, an operation code, the incoming carry and the result it computed. From these the block returns a 32-bit condition word. Carry, parity, adjust, zero, sign and overflow each sit at a fixed bit position. The block does not know whether the operands are signed. It always reports every flag, and a later consumer picks the signed or unsigned reading by choosing which bits it tests.

The carry-related flags (carry, adjust, overflow) come from a small internal carry chain over the operands and the effective carry-in. The result-related flags (zero, sign, parity) come from the result port. This keeps logical operations correct whatever unit produced their result. The combinational word is always available. A registered copy is also kept, and it loads only when the write enable is high.

Top module: `arith_flag_gen`

## Requirements
- R1: For op codes 0 (add) and 1 (add with carry), bit 0 is the carry out of the most significant bit of op_a + op_b + c. Here c is carry_in for code 1 and 0 for code 0.
- R2: For op codes 2 (subtract) and 3 (subtract with borrow), bit 0 is set when op_b + c exceeds op_a as unsigned numbers. Here c is carry_in for code 3 and 0 for code 2.
- R3: Bit 2 is 1 when the low 8 bits of result hold an even number of ones, for every op code.
- R4: For arithmetic codes, bit 4 is set on a carry (add) or borrow (subtract) out of bit 3 of the operation.
- R5: Bit 6 is 1 exactly when every bit of result is 0.
- R6: Bit 7 equals the most significant bit of result.
- R7: For arithmetic codes, bit 11 is set when the two's-complement result does not fit in DATA_W bits.
- R8: Op code 4 (logical), and the unused codes 5 to 7, force bits 0, 4 and 11 to 0.
- R9: Bit 1 of both words always reads 1, and every bit other than 0, 1, 2, 4, 6, 7 and 11 reads 0.
- R10: Synchronous active-high reset sets flags_q to 0x00000002.
- R11: flags_q takes the value of flags_comb at a rising edge where flag_we is 1, and holds its value when flag_we is 0.
- R12: carry_in has no effect on the flags for op codes 0, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 adc, 2 sub, 3 sbb, 4 logical) |
| carry_in | input | 1 | Incoming carry or borrow |
| result | input | DATA_W | Result produced by the datapath |
| flag_we | input | 1 | Load enable for the registered word |
| flags_comb | output | 32 | Combinational condition word |
| flags_q | output | 32 | Registered condition word |

## Verification
Overflow and adjust are the hardest flags to reach on purpose. Each needs a precise relation between the sign bits, or between the low nibbles, of the two operands and the incoming carry. The same holds for telling an ignored carry apart from a used one. The bench therefore builds an 8-bit instance and sweeps every value of op_a against a strided set of op_b that includes both ends of the range. It applies every op code and both carry_in values. This reaches signed wrap in both directions, nibble carries and borrows, and an all-zero result many times over. It computes each expected flag from plain integer arithmetic.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned POS_CF = 0;
  localparam int unsigned POS_ONE = 1;
  localparam int unsigned POS_PF = 2;
  localparam int unsigned POS_AF = 4;
  localparam int unsigned POS_ZF = 6;
  localparam int unsigned POS_SF = 7;
  localparam int unsigned POS_OF = 11;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0002;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_LOG = 3'd4
  } flag_op_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } flag_set_t;
endpackage

// File: rtl/arith_carry_chain.sv
module arith_carry_chain #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              invert_b,
  input  logic              cin,
  output logic              c_out,
  output logic              c_into_msb,
  output logic              c_nibble
);
  localparam int unsigned LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] bx;
  logic [DATA_W-1:0] low_sum;
  logic [4:0]        nib_sum;

  assign bx = invert_b ? ~b : b;

  always_comb begin
    low_sum = {1'b0, a[LOW_W-1:0]} + {1'b0, bx[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
    nib_sum = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'd0, cin};
  end

  assign c_into_msb = low_sum[DATA_W-1];
  assign c_out      = (a[DATA_W-1] & bx[DATA_W-1]) |
                      (c_into_msb & (a[DATA_W-1] ^ bx[DATA_W-1]));
  assign c_nibble   = nib_sum[4];
endmodule

// File: rtl/arith_result_flags.sv
module arith_result_flags #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  output logic              zero,
  output logic              sign,
  output logic              even_low
);
  assign zero     = ~|res;
  assign sign     = res[DATA_W-1];
  assign even_low = ~^res[7:0];
endmodule

// File: rtl/arith_flag_pack.sv
module arith_flag_pack
  import arith_flag_pkg::*;
(
  input  flag_set_t          fs,
  output logic [WORD_W-1:0]  word
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == POS_CF)       begin : g_cf  assign word[i] = fs.cf; end
    else if (i == POS_ONE) begin : g_one assign word[i] = 1'b1;  end
    else if (i == POS_PF)  begin : g_pf  assign word[i] = fs.pf; end
    else if (i == POS_AF)  begin : g_af  assign word[i] = fs.af; end
    else if (i == POS_ZF)  begin : g_zf  assign word[i] = fs.zf; end
    else if (i == POS_SF)  begin : g_sf  assign word[i] = fs.sf; end
    else if (i == POS_OF)  begin : g_of  assign word[i] = fs.of; end
    else                   begin : g_z   assign word[i] = 1'b0;  end
  end
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
  import arith_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        op_sel,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] result,
  input  logic              flag_we,
  output logic [31:0]       flags_comb,
  output logic [31:0]       flags_q
);
  flag_op_e  op;
  logic      is_arith;
  logic      is_sub;
  logic      cin_eff;
  logic      c_out;
  logic      c_msb;
  logic      c_nib;
  logic      zf;
  logic      sf;
  logic      pf;
  flag_set_t fs;

  assign op = flag_op_e'(op_sel);

  always_comb begin
    is_arith = 1'b1;
    is_sub   = 1'b0;
    cin_eff  = 1'b0;
    unique case (op)
      OP_ADD: cin_eff = 1'b0;
      OP_ADC: cin_eff = carry_in;
      OP_SUB: begin is_sub = 1'b1; cin_eff = 1'b1;      end
      OP_SBB: begin is_sub = 1'b1; cin_eff = ~carry_in; end
      default: is_arith = 1'b0;
    endcase
  end

  arith_carry_chain #(.DATA_W(DATA_W)) chain_i (
    .a          (op_a),
    .b          (op_b),
    .invert_b   (is_sub),
    .cin        (cin_eff),
    .c_out      (c_out),
    .c_into_msb (c_msb),
    .c_nibble   (c_nib)
  );

  arith_result_flags #(.DATA_W(DATA_W)) resf_i (
    .res      (result),
    .zero     (zf),
    .sign     (sf),
    .even_low (pf)
  );

  always_comb begin
    fs.cf = is_arith & (c_out ^ is_sub);
    fs.af = is_arith & (c_nib ^ is_sub);
    fs.of = is_arith & (c_out ^ c_msb);
    fs.pf = pf;
    fs.zf = zf;
    fs.sf = sf;
  end

  arith_flag_pack pack_i (
    .fs   (fs),
    .word (flags_comb)
  );

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= RESET_WORD;
    else if (flag_we) flags_q <= flags_comb;
  end
endmodule

// File: rtl/arith_flag_gen_chk.sv
module arith_flag_gen_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] result,
  input logic              flag_we,
  input logic [31:0]       flags_comb,
  input logic [31:0]       flags_q
);
  localparam logic [31:0] LIVE_MASK = 32'h0000_08D5;
  localparam logic [31:0] ARITH_ONLY = 32'h0000_0811;

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 3'd4) |-> ((flags_comb & ARITH_ONLY) == 32'd0));

  assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (rst)
    ((flags_comb & ~LIVE_MASK) == 32'h2) && ((flags_q & ~LIVE_MASK) == 32'h2));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    flags_comb[6] == (result == '0));

  assert_sign_flag_R6: assert property (@(posedge clk) disable iff (rst)
    flags_comb[7] == result[DATA_W-1]);

  assert_reset_word_R10: assert property (@(posedge clk)
    rst |=> (flags_q == 32'h2));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_q));

  assert_load_R11: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (flags_q == $past(flags_comb)));
endmodule

bind arith_flag_gen arith_flag_gen_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .op_sel     (op_sel),
  .result     (result),
  .flag_we    (flag_we),
  .flags_comb (flags_comb),
  .flags_q    (flags_q)
);

// File: tb/arith_flag_gen_tb.sv
`timescale 1ns/1ps
module arith_flag_gen_tb_top;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [2:0]   op_sel = 3'd0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result = '0;
  logic         flag_we = 1'b0;
  logic [31:0]  flags_comb;
  logic [31:0]  flags_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  arith_flag_gen #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .carry_in(carry_in), .result(result), .flag_we(flag_we),
    .flags_comb(flags_comb), .flags_q(flags_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d cin=%0b act=%h exp=%h",
               req, op_sel, op_a, op_b, carry_in, act, exp);
    end
  endtask

  // Drive one operation and compare every flag against integer arithmetic.
  task automatic apply(input int a, input int b, input int op, input int ci);
    int c, r, full;
    bit cf, af, of, pf, zf, sf, arith, sub;
    sub   = (op == 2) || (op == 3);
    arith = op < 4;
    c     = ((op == 1) || (op == 3)) ? ci : 0;
    if (!arith) begin
      r = (a ^ b) & MAXV; cf = 0; af = 0; of = 0;
    end else if (!sub) begin
      full = a + b + c; r = full & MAXV;
      cf = full > MAXV;
      af = ((a & 15) + (b & 15) + c) > 15;
      of = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    end else begin
      r  = (a - b - c) & MAXV;
      cf = a < (b + c);
      af = (a & 15) < ((b & 15) + c);
      of = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    end
    pf = ($countones(r & 255) % 2) == 0;
    zf = (r == 0);
    sf = r[W-1];
    op_a = W'(a); op_b = W'(b); op_sel = 3'(op); carry_in = ci[0]; result = W'(r);
    #1;
    check(sub ? "R2" : "R1", {31'd0, flags_comb[0]}, {31'd0, cf});
    check("R3", {31'd0, flags_comb[2]}, {31'd0, pf});
    check("R4", {31'd0, flags_comb[4]}, {31'd0, af});
    check("R5", {31'd0, flags_comb[6]}, {31'd0, zf});
    check("R6", {31'd0, flags_comb[7]}, {31'd0, sf});
    check("R7", {31'd0, flags_comb[11]}, {31'd0, of});
    check("R9", flags_comb & ~32'h8D5, 32'h2);
    if (!arith) check("R8", flags_comb & 32'h811, 32'd0);
    if ((op == 0 || op == 2 || op == 4) && ci == 1)
      check("R12", flags_comb,
            {20'd0, of, 3'd0, sf, zf, 1'b0, af, 1'b0, pf, 1'b1, cf});
  endtask

  initial begin
    logic [31:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", flags_q, 32'h2);
    rst = 1'b0;

    // combinational sweep, register held
    for (int a = 0; a <= MAXV; a++)
      for (int bi = 0; bi <= 37; bi++)
        for (int op = 0; op < 8; op++)
          for (int ci = 0; ci < 2; ci++)
            apply(a, (bi == 37) ? MAXV : bi * 7, op, ci);

    @(negedge clk);
    check("R10", flags_q, 32'h2);   // no load happened: still reset word (R11 hold)

    // R11: load with enable
    apply(127, 1, 0, 0);            // signed overflow: OF, SF, AF set
    snap = flags_comb;
    flag_we = 1'b1;
    @(negedge clk);
    check("R11", flags_q, snap);
    flag_we = 1'b0;
    apply(0, 0, 4, 0);
    @(negedge clk);
    @(negedge clk);
    check("R11", flags_q, snap);
    flag_we = 1'b1;
    @(negedge clk);
    check("R11", flags_q, 32'h46);
    flag_we = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R10", flags_q, 32'h2);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule